// File: doc/BRIEF.md
# Split-Bus Atomic Lock Guard

This unit sits between a bus endpoint and a memory port on a split-transaction bus. On such a bus, an atomic test-and-set is issued as an ordinary read followed later by an ordinary write to the same address. Other requests can be issued between the two. The atomic nature of the sequence cannot be seen once the read has finished, so the requester marks the read itself with an early atomic flag. The unit uses that flag to arm a hardware lock entry that holds the address and the requester ID.

While an entry is armed, any other requester that reads or writes the locked address gets a retry response, and its request does not reach memory. A flagged read to an address that another requester has locked is also refused. The owner's next write to the address completes the sequence and frees the entry. If the owner never writes, a per-entry age counter frees the lock once a programmable limit is reached and raises a one-cycle error pulse.

Every decision is registered. A request presented in one cycle appears in the next cycle, either on the memory side as a forwarded access or on the response side as a retry.

Top module: `tas_lock_unit`

## Requirements
- R1: After reset the unit holds no locks, and `mem_valid`, `rsp_valid` and `tmo_err` are low.
- R2: A plain access (`req_atomic`=0) to an unlocked address is forwarded one cycle later with unchanged address, ID, direction and write data. `rsp_valid`=1 and `rsp_retry`=0 in that same cycle.
- R3: A flagged read (`req_atomic`=1, `req_write`=0) to an unlocked address is forwarded and locks that address for `req_id`.
- R4: While an address is locked, reads and writes to it from any other ID give `rsp_retry`=1 one cycle later and are not forwarded (`mem_valid`=0). Accesses to other addresses are unaffected.
- R5: A flagged read to an address that another ID has locked is refused with a retry.
- R6: The owner's reads of its locked address are forwarded. The owner's write to that address is forwarded and frees the lock, after which other IDs are granted.
- R7: When all `ENTRIES` lock entries are in use, a flagged read to a new address is retried. Plain accesses to that address are still forwarded.
- R8: A lock that is not released is freed by the edge that comes `tmo_limit`+1 clock edges after the edge that armed it. `tmo_err` is high for exactly the one cycle after that edge.
- R9: When the owner repeats a flagged read to its own locked address, the read is granted and does not take a second entry.
- R10: Every valid request gets exactly one response in the next cycle: either a forward or a retry, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_limit | input | TMO_W | Lock age limit, in cycles |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_atomic | input | 1 | Early atomic flag; arms a lock on a read |
| req_id | input | ID_W | Requester ID |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| mem_valid | output | 1 | Forwarded access valid |
| mem_write | output | 1 | Forwarded direction |
| mem_id | output | ID_W | Forwarded requester ID |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded write data |
| rsp_valid | output | 1 | Decision for last cycle's request |
| rsp_retry | output | 1 | Request refused; requester must retry |
| rsp_id | output | ID_W | ID the decision belongs to |
| tmo_err | output | 1 | A lock was freed by age limit |

## Verification
The hardest situation to reach is the age-limit release. The lock must stay armed with no owner write for the full limit, and the error pulse must land on the exact expected cycle. The bench lowers the limit to a small value, arms one lock and then issues no requests. It checks `tmo_err` at every cycle of that window, so a pulse that comes one cycle early or late is caught, and it then shows that another ID is granted the freed address. A second hard case is a full lock table. The bench fills it from one ID, including repeated flagged reads to the same address, so that a leaked entry would show up as an early refusal.

// File: rtl/tas_pkg.sv
package tas_pkg;
   typedef enum logic [1:0] {
      DEC_IDLE  = 2'd0,
      DEC_GRANT = 2'd1,
      DEC_RETRY = 2'd2
   } tas_dec_e;
endpackage

// File: rtl/tas_lock_slot.sv
module tas_lock_slot #(
   parameter int ADDR_W = 16,
   parameter int ID_W   = 3,
   parameter int TMO_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              drop,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic [ID_W-1:0]   arm_id,
   input  logic [TMO_W-1:0]  limit,
   output logic              busy,
   output logic [ADDR_W-1:0] addr,
   output logic [ID_W-1:0]   id,
   output logic              expire
);
   logic [TMO_W-1:0] age;

   assign expire = busy && (age >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         age  <= '0;
         addr <= '0;
         id   <= '0;
      end else if (arm) begin
         busy <= 1'b1;
         age  <= '0;
         addr <= arm_addr;
         id   <= arm_id;
      end else if (busy && (drop || expire)) begin
         busy <= 1'b0;
         age  <= '0;
      end else if (busy) begin
         age  <= age + 1'b1;
      end
   end
endmodule

// File: rtl/tas_slot_pick.sv
module tas_slot_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] free_vec,
   output logic [N-1:0] pick_oh,
   output logic         any_free
);
   always_comb begin
      pick_oh = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free_vec[i]) pick_oh = '0 | (N'(1) << i);
      end
   end
   assign any_free = |free_vec;
endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int ID_W    = 3,
   parameter int ENTRIES = 4,
   parameter int TMO_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_atomic,
   input  logic [ID_W-1:0]   req_id,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ID_W-1:0]   mem_id,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              rsp_valid,
   output logic              rsp_retry,
   output logic [ID_W-1:0]   rsp_id,
   output logic              tmo_err
);
   import tas_pkg::*;

   initial begin
      assert (ENTRIES >= 1) else $fatal(1, "ENTRIES must be at least 1");
      assert (ADDR_W >= 1 && DATA_W >= 1 && ID_W >= 1) else $fatal(1, "widths must be positive");
      assert (TMO_W >= 2) else $fatal(1, "TMO_W must be at least 2");
   end

   logic [ENTRIES-1:0] slot_busy, slot_expire, slot_arm, slot_drop;
   logic [ENTRIES-1:0] addr_hit, own_hit, free_oh;
   logic [ADDR_W-1:0]  slot_addr [ENTRIES];
   logic [ID_W-1:0]    slot_id   [ENTRIES];
   logic               any_free, tas_read, foreign_hit, own_any;
   tas_dec_e           dec;

   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_slot
         tas_lock_slot #(.ADDR_W(ADDR_W), .ID_W(ID_W), .TMO_W(TMO_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (slot_arm[g]),
            .drop     (slot_drop[g]),
            .arm_addr (req_addr),
            .arm_id   (req_id),
            .limit    (tmo_limit),
            .busy     (slot_busy[g]),
            .addr     (slot_addr[g]),
            .id       (slot_id[g]),
            .expire   (slot_expire[g])
         );
         assign addr_hit[g] = slot_busy[g] && (slot_addr[g] == req_addr);
         assign own_hit[g]  = addr_hit[g] && (slot_id[g] == req_id);
      end
   endgenerate

   tas_slot_pick #(.N(ENTRIES)) u_pick (
      .free_vec (~slot_busy),
      .pick_oh  (free_oh),
      .any_free (any_free)
   );

   assign tas_read    = req_atomic && !req_write;
   assign foreign_hit = |(addr_hit & ~own_hit);
   assign own_any     = |own_hit;

   always_comb begin
      if (!req_valid)                                   dec = DEC_IDLE;
      else if (foreign_hit)                             dec = DEC_RETRY;
      else if (tas_read && !own_any && !any_free)       dec = DEC_RETRY;
      else                                              dec = DEC_GRANT;
   end

   always_comb begin
      slot_arm  = '0;
      slot_drop = '0;
      if (dec == DEC_GRANT) begin
         if (tas_read)       slot_arm  = own_any ? own_hit : free_oh;
         else if (req_write) slot_drop = own_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_valid <= 1'b0;
         mem_write <= 1'b0;
         mem_id    <= '0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         rsp_valid <= 1'b0;
         rsp_retry <= 1'b0;
         rsp_id    <= '0;
         tmo_err   <= 1'b0;
      end else begin
         mem_valid <= (dec == DEC_GRANT);
         mem_write <= req_write;
         mem_id    <= req_id;
         mem_addr  <= req_addr;
         mem_wdata <= req_wdata;
         rsp_valid <= (dec != DEC_IDLE);
         rsp_retry <= (dec == DEC_RETRY);
         rsp_id    <= req_id;
         tmo_err   <= |(slot_expire & ~slot_arm);
      end
   end
endmodule

// File: rtl/tas_lock_unit_chk.sv
module tas_lock_unit_chk #(
   parameter int N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic         mem_valid,
   input logic         rsp_valid,
   input logic         rsp_retry,
   input logic         tmo_err,
   input logic [N-1:0] busy
);
   // R10
   resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !mem_valid));

   // R4
   retry_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_retry |-> !mem_valid);

   // R2
   grant_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_retry) |-> mem_valid);

   // R8
   tmo_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_err |-> ($past(busy) != '0));
endmodule

bind tas_lock_unit tas_lock_unit_chk #(.N(ENTRIES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .mem_valid (mem_valid),
   .rsp_valid (rsp_valid),
   .rsp_retry (rsp_retry),
   .tmo_err   (tmo_err),
   .busy      (slot_busy)
);

// File: tb/sim_tas_lock_unit.sv
module sim_tas_lock_unit;
   localparam int ADDR_W = 16, DATA_W = 32, ID_W = 3, ENTRIES = 4, TMO_W = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [TMO_W-1:0]  tmo_limit = 12'd1000;
   logic              req_valid = 1'b0, req_write = 1'b0, req_atomic = 1'b0;
   logic [ID_W-1:0]   req_id = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              mem_valid, mem_write, rsp_valid, rsp_retry, tmo_err;
   logic [ID_W-1:0]   mem_id, rsp_id;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   tas_lock_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
                   .ENTRIES(ENTRIES), .TMO_W(TMO_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
      .req_valid(req_valid), .req_write(req_write), .req_atomic(req_atomic),
      .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_id(mem_id),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_id(rsp_id),
      .tmo_err(tmo_err));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Issue one request; sample the decision one cycle later.
   task automatic access(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                         input bit wr, input bit at, input logic [DATA_W-1:0] d,
                         output bit fwd, output bit rty);
      @(negedge clk);
      req_valid = 1'b1; req_id = id; req_addr = a; req_write = wr;
      req_atomic = at; req_wdata = d;
      @(negedge clk);
      fwd = mem_valid; rty = rsp_retry;
      req_valid = 1'b0; req_atomic = 1'b0; req_write = 1'b0;
   endtask

   task automatic expect_acc(input string tag, input logic [ID_W-1:0] id,
                             input logic [ADDR_W-1:0] a, input bit wr, input bit at,
                             input bit exp_fwd);
      bit f, r;
      access(id, a, wr, at, 32'hA5A5_0000 | a, f, r);
      chk(f == exp_fwd && r == !exp_fwd && rsp_valid, tag, {f, r}, {exp_fwd, !exp_fwd});
   endtask

   task automatic t_reset;
      chk(!mem_valid && !rsp_valid && !tmo_err, "R1 reset outputs", {mem_valid, rsp_valid, tmo_err}, 0);
      expect_acc("R1 no lock after reset", 3'd5, 16'h0010, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_plain;
      bit f, r;
      access(3'd2, 16'h1234, 1'b1, 1'b0, 32'hDEAD_BEEF, f, r);
      chk(f && !r && mem_write && mem_addr == 16'h1234 && mem_id == 3'd2
          && mem_wdata == 32'hDEAD_BEEF && rsp_id == 3'd2,
          "R2 write forwarded", mem_wdata, 32'hDEAD_BEEF);
      access(3'd6, 16'h00FF, 1'b0, 1'b0, 32'h0, f, r);
      chk(f && !r && !mem_write && mem_addr == 16'h00FF && mem_id == 3'd6,
          "R2 read forwarded", mem_addr, 16'h00FF);
   endtask

   task automatic t_lock_conflict;
      expect_acc("R3 tas read granted", 3'd1, 16'h0100, 1'b0, 1'b1, 1'b1);
      expect_acc("R4 foreign read retried", 3'd2, 16'h0100, 1'b0, 1'b0, 1'b0);
      expect_acc("R4 foreign write retried", 3'd3, 16'h0100, 1'b1, 1'b0, 1'b0);
      expect_acc("R4 other addr unaffected", 3'd2, 16'h0101, 1'b0, 1'b0, 1'b1);
      expect_acc("R5 foreign tas refused", 3'd2, 16'h0100, 1'b0, 1'b1, 1'b0);
      expect_acc("R6 owner read granted", 3'd1, 16'h0100, 1'b0, 1'b0, 1'b1);
      expect_acc("R6 owner write granted", 3'd1, 16'h0100, 1'b1, 1'b0, 1'b1);
      expect_acc("R6 freed after owner write", 3'd2, 16'h0100, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_full_and_relock;
      expect_acc("R9 first lock", 3'd4, 16'h0200, 1'b0, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++)
         expect_acc("R9 owner relock granted", 3'd4, 16'h0200, 1'b0, 1'b1, 1'b1);
      for (int k = 1; k < ENTRIES; k++)
         expect_acc("R9 remaining slots free", 3'd4, 16'h0200 + 16'(k), 1'b0, 1'b1, 1'b1);
      expect_acc("R7 table full tas retried", 3'd4, 16'h0300, 1'b0, 1'b1, 1'b0);
      expect_acc("R7 plain access still granted", 3'd4, 16'h0300, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < ENTRIES; k++)
         expect_acc("R6 release by owner write", 3'd4, 16'h0200 + 16'(k), 1'b1, 1'b0, 1'b1);
      expect_acc("R7 slot usable after release", 3'd0, 16'h0300, 1'b0, 1'b1, 1'b1);
      expect_acc("R6 release", 3'd0, 16'h0300, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_timeout;
      bit f, r;
      tmo_limit = 12'd5;
      // arming edge happens inside access; sample after it
      access(3'd7, 16'h0400, 1'b0, 1'b1, 32'h0, f, r);
      chk(f && !r, "R8 lock armed", f, 1);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         chk(!tmo_err, "R8 no early timeout", tmo_err, 0);
      end
      @(negedge clk);
      chk(tmo_err, "R8 timeout pulse", tmo_err, 1);
      @(negedge clk);
      chk(!tmo_err, "R8 pulse one cycle", tmo_err, 0);
      expect_acc("R8 freed after timeout", 3'd1, 16'h0400, 1'b1, 1'b0, 1'b1);
      tmo_limit = 12'd1000;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_lock_conflict();
      t_full_and_relock();
      t_timeout();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule